// File: doc/BRIEF.md
# Interleaved Dual-Stimulus Code Histogram Collector

This block builds two code histograms from a stream of converter output codes taken under two analog test stimuli. The second stimulus is the first one moved by a fixed offset. Each stimulus sweeps the whole input range. A sequencer drives a select line to the external stimulus generator. The first stimulus is acquired in two equal halves, and a shorter, lower-density pass of the second stimulus sits between them. Because the second pass is centred in time, a slow drift that changes linearly over the run shifts the average of both data sets by the same amount.

Software writes one density in samples per code for each stimulus and pulses the start input. The pulse clears both histograms and fixes the configuration. While codes arrive on a valid-qualified input, each counted sample increments one counter in the histogram bank of the stimulus currently selected. The sample right after every change of stimulus is thrown away so the generator can settle. When the third phase ends, the done flag rises, and the counts can then be read through a bank and address port. Counters stop at their maximum value instead of wrapping, and a sticky flag records that a count was lost.

Top module: `hcol_top`

## Requirements
- R1: After reset, done, stim_sel and overflow are 0, and rd_data reads 0.
- R2: A start pulse clears every counter in both banks, clears overflow, captures dens1 and dens2, and enters the first phase with stim_sel = 0. A start pulse during an acquisition abandons it and restarts.
- R3: The phases run in a fixed order. Phase 1 counts dens1*N/2 samples with stim_sel = 0. Phase 2 counts dens2*N samples with stim_sel = 1. Phase 3 counts dens1*N/2 samples with stim_sel = 0. N = 2^CODE_W.
- R4: In each phase, including the first, the first valid sample is discarded. It is not counted in any bank and does not count toward the phase total.
- R5: Each counted sample adds one to the counter at index code. It goes to bank 0 while stim_sel = 0 and to bank 1 while stim_sel = 1.
- R6: Cycles with code_vld = 0 have no effect, whatever the value on code.
- R7: A counter that is already at 2^CNT_W-1 stays there when a sample lands on it, and overflow is set. Overflow stays set until the next start.
- R8: A density of 0 is taken as 1.
- R9: done rises in the cycle after the last counted sample of phase 3 and stays high until the next start. Samples that arrive while done is high, or before the first start, change no count.
- R10: While done = 1, rd_data returns the counter selected by rd_bank (0 or 1) and rd_addr. While done = 0, rd_data reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear banks, capture densities, begin acquisition |
| code_vld | input | 1 | code carries a sample this cycle |
| code | input | CODE_W | Converter output code |
| dens1 | input | DENS_W | Samples per code for stimulus 1 |
| dens2 | input | DENS_W | Samples per code for stimulus 2 |
| stim_sel | output | 1 | Stimulus select to the generator (0 first, 1 second) |
| done | output | 1 | Acquisition finished, counts readable |
| overflow | output | 1 | Sticky: a count was lost to saturation |
| rd_bank | input | 1 | Bank to read |
| rd_addr | input | CODE_W | Code index to read |
| rd_data | output | CNT_W | Selected counter value |

## Verification
Assertions check on every cycle the properties that hold locally. The select line changes only at a phase boundary, where the drop flag is armed and the phase count is zero. The phase counter never reaches its target without moving on. A counted sample adds exactly one or holds at the ceiling, and at most one bank is written per cycle. The overflow flag stays set until a start, and the select line is low while done is high. Only the bench scenarios can show the full histogram contents after a run, the exact length and order of the phases, the effect of clamping a zero density, the clearing on a restart, and that samples after done are ignored. The bench checks these against its own model of the schedule.

// File: rtl/hcol_pkg.sv
package hcol_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_S1_HEAD = 3'd1,
        PH_S2      = 3'd2,
        PH_S1_TAIL = 3'd3,
        PH_DONE    = 3'd4
    } phase_e;

    // Order of the schedule: head of stimulus 1, stimulus 2, tail of stimulus 1.
    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_S1_HEAD: return PH_S2;
            PH_S2:      return PH_S1_TAIL;
            PH_S1_TAIL: return PH_DONE;
            default:    return p;
        endcase
    endfunction

    function automatic logic is_acquiring(phase_e p);
        return (p == PH_S1_HEAD) || (p == PH_S2) || (p == PH_S1_TAIL);
    endfunction

endpackage

// File: rtl/hcol_seq.sv
module hcol_seq
    import hcol_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int DENS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              code_vld,
    input  logic [DENS_W-1:0] dens1,
    input  logic [DENS_W-1:0] dens2,
    output logic              clr,
    output logic              inc_en,
    output logic              inc_bank,
    output logic              stim_sel,
    output logic              done
);
    localparam int TGT_W = DENS_W + CODE_W;

    phase_e            phase_q;
    logic              settle_q;
    logic [TGT_W-1:0]  cnt_q;
    logic [DENS_W-1:0] d1_q, d2_q;
    logic [TGT_W-1:0]  tgt_half, tgt_mid, tgt;
    logic              take, last;

    always_comb begin
        tgt_half = TGT_W'(d1_q) << (CODE_W - 1);
        tgt_mid  = TGT_W'(d2_q) << CODE_W;
        tgt      = (phase_q == PH_S2) ? tgt_mid : tgt_half;
        take     = is_acquiring(phase_q) && code_vld && !start;
        inc_en   = take && !settle_q;
        last     = inc_en && ((cnt_q + 1'b1) == tgt);
    end

    assign clr      = start;
    assign inc_bank = (phase_q == PH_S2);
    assign stim_sel = (phase_q == PH_S2);
    assign done     = (phase_q == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            settle_q <= 1'b0;
            cnt_q    <= '0;
            d1_q     <= DENS_W'(1);
            d2_q     <= DENS_W'(1);
        end else if (start) begin
            phase_q  <= PH_S1_HEAD;
            settle_q <= 1'b1;
            cnt_q    <= '0;
            d1_q     <= (dens1 == '0) ? DENS_W'(1) : dens1;
            d2_q     <= (dens2 == '0) ? DENS_W'(1) : dens2;
        end else if (take) begin
            if (settle_q) begin
                settle_q <= 1'b0;
            end else if (last) begin
                phase_q  <= next_phase(phase_q);
                cnt_q    <= '0;
                settle_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the select line moves only at a phase boundary.
    assert_sel_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(stim_sel) |-> (settle_q && cnt_q == '0));

    // R3: a phase never reaches its target without moving on.
    assert_cnt_below_target_R3: assert property (@(posedge clk) disable iff (rst)
        is_acquiring(phase_q) |-> (cnt_q < tgt));

    // R4: entering stimulus 2 arms the drop of its first sample.
    assert_drop_armed_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stim_sel) |-> settle_q);

    // R9: select is low while done.
    assert_done_sel_low_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !stim_sel);

endmodule

// File: rtl/hcol_bank.sv
module hcol_bank #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc_en,
    input  logic [CODE_W-1:0] inc_code,
    input  logic [CODE_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic              sat_hit
);
    localparam int NBIN = 1 << CODE_W;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] bins_q [NBIN];

    assign rd_cnt  = bins_q[rd_addr];
    assign sat_hit = inc_en && (bins_q[inc_code] == CMAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < NBIN; i++) bins_q[i] <= '0;
        end else if (inc_en && (bins_q[inc_code] != CMAX)) begin
            bins_q[inc_code] <= bins_q[inc_code] + 1'b1;
        end
    end

    // R5: a counted sample adds exactly one below the ceiling.
    assert_inc_by_one_R5: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !clr && bins_q[inc_code] != CMAX)
        |=> (bins_q[$past(inc_code)] == $past(bins_q[inc_code]) + 1'b1));

    // R7: a counter at the ceiling stays there.
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !clr && bins_q[inc_code] == CMAX)
        |=> (bins_q[$past(inc_code)] == CMAX));

endmodule

// File: rtl/hcol_top.sv
module hcol_top
    import hcol_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 16,
    parameter int DENS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code,
    input  logic [DENS_W-1:0] dens1,
    input  logic [DENS_W-1:0] dens2,
    output logic              stim_sel,
    output logic              done,
    output logic              overflow,
    input  logic              rd_bank,
    input  logic [CODE_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int NBANK = 2;

    logic             clr, inc_en, inc_bank;
    logic [NBANK-1:0] bank_inc, bank_sat;
    logic [CNT_W-1:0] bank_rd [NBANK];
    logic             ovf_q;

    hcol_seq #(.CODE_W(CODE_W), .DENS_W(DENS_W)) seq_i (
        .clk(clk), .rst(rst), .start(start), .code_vld(code_vld),
        .dens1(dens1), .dens2(dens2), .clr(clr), .inc_en(inc_en),
        .inc_bank(inc_bank), .stim_sel(stim_sel), .done(done)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_inc[b] = inc_en && (inc_bank == 1'(b));
        hcol_bank #(.CODE_W(CODE_W), .CNT_W(CNT_W)) bank_i (
            .clk(clk), .rst(rst), .clr(clr), .inc_en(bank_inc[b]),
            .inc_code(code), .rd_addr(rd_addr), .rd_cnt(bank_rd[b]),
            .sat_hit(bank_sat[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr)      ovf_q <= 1'b0;
        else if (|bank_sat)  ovf_q <= 1'b1;
    end

    assign overflow = ovf_q;
    assign rd_data  = done ? bank_rd[rd_bank] : '0;

    // R5: at most one bank takes a sample in any cycle.
    assert_one_bank_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_inc));

    // R7: overflow is sticky until a start.
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (overflow && !start) |=> overflow);

    // R9: no bank is written while done.
    assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (bank_inc == '0));

endmodule

// File: tb/hcol_top_tb_top.sv
`timescale 1ns/1ps
module hcol_top_tb_top;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 4;
    localparam int DENS_W = 6;
    localparam int N      = 1 << CODE_W;
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam int NRUN   = 5;

    // Run table: densities, code offset and stride of the sample stream.
    localparam int RUN_D1  [NRUN] = '{2, 1, 4, 2, 8};
    localparam int RUN_D2  [NRUN] = '{1, 0, 1, 2, 1};
    localparam int RUN_OFF [NRUN] = '{1, 3, 2, 0, 0};
    localparam int RUN_STR [NRUN] = '{1, 3, 0, 5, 1};

    logic clk = 1'b0;
    logic rst, start, code_vld, rd_bank, stim_sel, done, overflow;
    logic [CODE_W-1:0] code, rd_addr;
    logic [DENS_W-1:0] dens1, dens2;
    logic [CNT_W-1:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int e0 [N];
    int e1 [N];
    bit e_ovf;

    always #2.5 clk = ~clk;

    hcol_top #(.CODE_W(CODE_W), .CNT_W(CNT_W), .DENS_W(DENS_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .code_vld(code_vld), .code(code),
        .dens1(dens1), .dens2(dens2), .stim_sel(stim_sel), .done(done),
        .overflow(overflow), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int c, input int gap);
        @(negedge clk);
        code_vld = 1'b1;
        code     = CODE_W'(c);
        @(negedge clk);
        code_vld = 1'b0;
        code     = ~CODE_W'(c);   // R6: garbage on code while not valid
        repeat (gap) @(negedge clk);
    endtask

    task automatic pulse_start(input int d1, input int d2);
        @(negedge clk);
        start = 1'b1;
        dens1 = DENS_W'(d1);
        dens2 = DENS_W'(d2);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic read_bin(input int b, input int a, output int v);
        @(negedge clk);
        rd_bank = 1'(b);
        rd_addr = CODE_W'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic check_bins(input string tag);
        int v;
        for (int a = 0; a < N; a++) begin
            read_bin(0, a, v);
            chk(v == e0[a], {tag, " R5 R6 bank0"}, v, e0[a]);
            read_bin(1, a, v);
            chk(v == e1[a], {tag, " R5 R6 bank1"}, v, e1[a]);
        end
    endtask

    // Full acquisition with a bench-side model of the schedule.
    task automatic run(input int d1, input int d2, input int off, input int str);
        int ph, c, j, tgt, cd, dc1, dc2;
        bit settle;
        dc1 = (d1 == 0) ? 1 : d1;   // R8
        dc2 = (d2 == 0) ? 1 : d2;
        for (int a = 0; a < N; a++) begin e0[a] = 0; e1[a] = 0; end
        e_ovf = 1'b0;
        pulse_start(d1, d2);
        chk(overflow == 1'b0, "R2 overflow cleared", int'(overflow), 0);
        ph = 0; c = 0; j = 0; settle = 1'b1;
        while (ph < 3) begin
            tgt = (ph == 1) ? dc2 * N : dc1 * N / 2;
            cd  = (off + j * str) % N;
            chk(stim_sel == (ph == 1), "R3 stim_sel", int'(stim_sel), int'(ph == 1));
            chk(done == 1'b0, "R9 done early", int'(done), 0);
            send(cd, j % 3);
            if (settle) begin
                settle = 1'b0;          // R4 dropped sample
            end else begin
                if (ph == 1) begin
                    if (e1[cd] == CMAX) e_ovf = 1'b1; else e1[cd]++;
                end else begin
                    if (e0[cd] == CMAX) e_ovf = 1'b1; else e0[cd]++;
                end
                c++;
                if (c == tgt) begin ph++; c = 0; settle = 1'b1; end
            end
            j++;
        end
        chk(done == 1'b1, "R9 done after phase 3", int'(done), 1);
        chk(stim_sel == 1'b0, "R3 stim_sel after done", int'(stim_sel), 0);
        chk(overflow == e_ovf, "R7 overflow", int'(overflow), int'(e_ovf));
        check_bins("run");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        rst = 1'b1; start = 1'b0; code_vld = 1'b0; code = '0;
        dens1 = '0; dens2 = '0; rd_bank = 1'b0; rd_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(stim_sel == 1'b0, "R1 stim_sel", int'(stim_sel), 0);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        chk(rd_data == '0, "R1 rd_data", int'(rd_data), 0);

        // R9: samples before any start are ignored
        for (int k = 0; k < 4; k++) send(k, 0);
        chk(done == 1'b0, "R9 idle done", int'(done), 0);

        // Table walk: R3 R4 R5 R6 R7 (saturating run) R8 (dens2 = 0)
        for (int r = 0; r < NRUN; r++) run(RUN_D1[r], RUN_D2[r], RUN_OFF[r], RUN_STR[r]);

        // R9: samples after done change nothing
        for (int k = 0; k < 6; k++) send(k % N, 0);
        chk(done == 1'b1, "R9 done holds", int'(done), 1);
        check_bins("R9 post-done");

        // R10: reads give 0 while not done
        pulse_start(2, 1);
        send(0, 0); send(0, 0); send(0, 0);
        read_bin(0, 0, v);
        chk(v == 0, "R10 read while busy", v, 0);

        // R2: restart in mid-run clears everything and starts over
        run(2, 1, 5, 1);

        // R7 then R2: saturate, then a clean run must clear overflow
        run(4, 1, 6, 0);
        chk(overflow == 1'b1, "R7 sticky after run", int'(overflow), 1);
        run(1, 1, 0, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule